// File: doc/BRIEF.md
# Single-Button Five-Speed Fan Selector

This block lets one push button cycle a fan through "off" and five speed levels. The raw button level is synchronized and debounced. Each accepted press yields a single one-clock step strobe, and that strobe advances a three-bit speed value through 0, 1, 2, 3, 4, 5 and back to 0.

The speed value is decoded into five active-high relay enables, one per speed, with all of them low when the fan is off. The same value also drives a single active-low seven-segment digit that shows the selected speed. The setting is held only in flip-flops, so every reset or power-up begins at speed 0.

Top module: `fan_speed_sel`

## Requirements
- R1: After reset, `speed_o` is 0, `relay_o` is all zero and `seg_no` shows the digit 0.
- R2: Each accepted press advances `speed_o` by exactly one step. A press at speed 5 returns it to 0 as a synchronous next state.
- R3: Button level changes that last fewer than `DEB_CYCLES` clock cycles are ignored. A button held down for any length of time gives only one step.
- R4: `speed_o` only ever takes the values 0 to 5.
- R5: At speed n (1 to 5), only `relay_o[n-1]` is high. No more than one relay enable is ever high.
- R6: At speed 0, every relay enable is low.
- R7: `seg_no` is active low, with bit 6 = segment a down to bit 0 = segment g. It shows the decimal digit of the current speed.
- R8: Releasing the button, including a bouncy release, never changes the speed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | 1 | Raw push-button level, high = pressed |
| speed_o | output | 3 | Current speed, 0 = off |
| relay_o | output | 5 | One-hot relay enables, bit n-1 = speed n |
| seg_no | output | 7 | Seven-segment digit, active low, a..g = bits 6..0 |

## Verification
A press that stays stable reaches `speed_o` about `DEB_CYCLES` + 5 cycles after the button edge. The path is two synchronizer stages, the debounce window, the strobe register and the strobe falling-edge detect. `relay_o` and `seg_no` follow one cycle after `speed_o`. The bench therefore holds each level for `DEB_CYCLES` + 12 cycles and samples on the falling clock edge after that, well past all result latencies. Bounce pulses are kept shorter than half the window, so they must never complete a debounce.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam int unsigned NUM_SPD = 5;
  localparam int unsigned SPD_W   = $clog2(NUM_SPD + 1);
  localparam int unsigned SEG_W   = 7;
endpackage

// File: rtl/fan_btn_cond.sv
module fan_btn_cond #(
  parameter int unsigned DEB_CYCLES = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic step_o
);
  localparam int unsigned CNT_W = $clog2(DEB_CYCLES + 1);

  logic [1:0]       sync_q;
  logic             deb_q;
  logic             deb_d1_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], btn_i};
  end

  // level must differ from the accepted state for the full window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      deb_q <= 1'b0;
    end else if (sync_q[1] == deb_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_W'(DEB_CYCLES - 1)) begin
      cnt_q <= '0;
      deb_q <= sync_q[1];
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deb_d1_q <= 1'b0;
      step_o   <= 1'b0;
    end else begin
      deb_d1_q <= deb_q;
      step_o   <= deb_q & ~deb_d1_q;
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o); // R3
  AST_NO_STEP_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> deb_d1_q); // R8
endmodule

// File: rtl/fan_speed_ctr.sv
module fan_speed_ctr
  import fan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [SPD_W-1:0] speed_o
);
  logic step_q;
  logic adv;

  // advance on the trailing edge of the step strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= 1'b0;
    else         step_q <= step_i;
  end
  assign adv = step_q & ~step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        speed_o <= '0;
    else if (adv && speed_o == SPD_W'(NUM_SPD)) speed_o <= '0;
    else if (adv)                       speed_o <= speed_o + 1'b1;
  end

  AST_SPEED_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speed_o <= SPD_W'(NUM_SPD)); // R4
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> speed_o == (($past(speed_o) == SPD_W'(NUM_SPD)) ? '0 : $past(speed_o) + 1'b1)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> $stable(speed_o)); // R2
endmodule

// File: rtl/fan_out_dec.sv
module fan_out_dec
  import fan_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SPD_W-1:0]   speed_i,
  output logic [NUM_SPD-1:0] relay_o,
  output logic [SEG_W-1:0]   seg_no
);
  logic [NUM_SPD-1:0] relay_d;
  logic [SEG_W-1:0]   seg_on;

  for (genvar i = 0; i < NUM_SPD; i++) begin : g_relay
    assign relay_d[i] = (speed_i == SPD_W'(i + 1));
  end

  // active-high a..g on bits 6..0
  always_comb begin
    unique case (speed_i)
      3'd0:    seg_on = 7'b1111110;
      3'd1:    seg_on = 7'b0110000;
      3'd2:    seg_on = 7'b1101101;
      3'd3:    seg_on = 7'b1111001;
      3'd4:    seg_on = 7'b0110011;
      3'd5:    seg_on = 7'b1011011;
      default: seg_on = 7'b0000001;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      relay_o <= '0;
      seg_no  <= ~7'b1111110;
    end else begin
      relay_o <= relay_d;
      seg_no  <= ~seg_on;
    end
  end

  AST_RELAY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(relay_o)); // R5
  AST_RELAY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_i == '0) |=> (relay_o == '0)); // R6
  AST_RELAY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_i != '0) |=> $countones(relay_o) == 1); // R5
endmodule

// File: rtl/fan_speed_sel.sv
module fan_speed_sel
  import fan_pkg::*;
#(
  parameter int unsigned DEB_CYCLES = 2_500_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               btn_i,
  output logic [SPD_W-1:0]   speed_o,
  output logic [NUM_SPD-1:0] relay_o,
  output logic [SEG_W-1:0]   seg_no
);
  logic step;

  fan_btn_cond #(.DEB_CYCLES(DEB_CYCLES)) u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  (btn_i),
    .step_o (step)
  );

  fan_speed_ctr u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .speed_o (speed_o)
  );

  fan_out_dec u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .speed_i (speed_o),
    .relay_o (relay_o),
    .seg_no  (seg_no)
  );
endmodule

// File: tb/fan_speed_sel_bench.sv
module fan_speed_sel_bench;
  localparam int unsigned DEB = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       btn_i = 1'b0;
  logic [2:0] speed_o;
  logic [4:0] relay_o;
  logic [6:0] seg_no;

  int n_chk = 0;
  int n_fail = 0;
  int exp_spd = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  fan_speed_sel #(.DEB_CYCLES(DEB)) u_fan_speed_sel (
    .clk_i (clk_i), .rst_ni (rst_ni), .btn_i (btn_i),
    .speed_o (speed_o), .relay_o (relay_o), .seg_no (seg_no)
  );

  function automatic logic [4:0] exp_relay(int s);
    return (s == 0) ? 5'd0 : 5'(1 << (s - 1));
  endfunction

  function automatic logic [6:0] exp_seg(int s);
    logic [6:0] on;
    case (s)
      0: on = 7'b1111110; 1: on = 7'b0110000; 2: on = 7'b1101101;
      3: on = 7'b1111001; 4: on = 7'b0110011; default: on = 7'b1011011;
    endcase
    return ~on;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 R4 speed"}, 32'(speed_o), 32'(exp_spd));
    chk({tag, " R5 R6 relay"}, 32'(relay_o), 32'(exp_relay(exp_spd)));
    chk({tag, " R5 onehot"}, 32'($countones(relay_o) <= 1), 32'd1);
    chk({tag, " R7 seg"}, 32'(seg_no), 32'(exp_seg(exp_spd)));
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bounce(logic final_lvl);
    int k = 2 + int'($urandom % 4);
    for (int i = 0; i < k; i++) begin
      btn_i = (i % 2 == 0) ? final_lvl : ~final_lvl;
      wait_cyc(1 + int'($urandom % (DEB / 2)));
      btn_i = ~btn_i;
      wait_cyc(1 + int'($urandom % (DEB / 2)));
    end
    btn_i = final_lvl;
  endtask

  task automatic press(bit bouncy, int hold);
    if (bouncy) bounce(1'b1);
    else btn_i = 1'b1;
    wait_cyc(DEB + 12 + hold);
    exp_spd = (exp_spd == 5) ? 0 : exp_spd + 1;
    check_all("press");
    if (bouncy) bounce(1'b0);
    else btn_i = 1'b0;
    wait_cyc(DEB + 12);
    check_all("release R8");
  endtask

  initial begin
    void'($urandom(32'd1234));
    wait_cyc(3);
    check_all("reset R1");
    rst_ni = 1'b1;
    wait_cyc(3);
    check_all("reset R1");
    // short glitches only: R3 no step
    btn_i = 1'b1; wait_cyc(DEB / 2); btn_i = 1'b0; wait_cyc(DEB + 12);
    check_all("glitch R3");
    for (int p = 0; p < 13; p++) begin
      if (p == 3) press(1'b0, 6 * DEB);   // long hold R3
      else press(($urandom % 2) == 1 || p == 7, int'($urandom % 20));
    end
    // reset mid-sequence returns to off R1
    rst_ni = 1'b0; exp_spd = 0; wait_cyc(2);
    check_all("reset R1");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100_000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule